// File: doc/BRIEF.md
# LIN Slave Break and Sync Detector

This block sits on the receive side of a LIN slave node. It passes the serial line through a two-flop synchronizer and watches for falling edges on the result. A bit timer divides the oversampling tick by the current baud divisor. That timer restarts on every falling edge, so it stays phased to start bits with no help from software. When the line stays dominant (low) for twelve bit times, the block raises a sticky break flag. That flag doubles as the interrupt level. If only break detection is wanted, a mask can silence the framing-error pulse that a long low would otherwise produce after nine bit times.

Software clears the break flag by writing one to `clr_brk`. The block then arms itself for the sync field. The first falling edge after arming opens a capture window (`sync_win` high). The fifth falling edge closes it. Because the sync byte alternates its bits, those two edges lie eight bit times apart. A free-running 16-bit tick timer measures the span. The span divided by eight, minus one, becomes the new baud divisor. It appears on `reload_out` with a one-cycle `reload_vld` strobe and takes effect in the bit timer at once.

The state machine has four states. **IDLE** counts low bit times and leaves to HELD on the break transition. **HELD** holds the flag and goes to ARMED on the clear transition (`clr_brk` = 1). **ARMED** waits and goes to SYNC on the open transition (first falling edge). **SYNC** counts edges and returns to IDLE on the close transition (fifth falling edge), where the divisor is loaded.

Top module: `lin_brk_sync`

## Requirements
- R1: After reset, `brk_flag`, `err_pulse`, `sync_win` and `reload_vld` are 0 and `reload_out` equals the parameter `DEF_RELOAD` (default 15).
- R2: A bit time is `reload_out`+1 ticks of `os_tick`. A low that covers twelve bit times sets `brk_flag`. A low shorter than twelve bit times leaves it at 0.
- R3: A high level on the synchronized input before the threshold resets the low-time count. Two lows of eight bit times each, with a high between them, set neither `brk_flag` nor `err_pulse`.
- R4: In IDLE, when a low reaches nine bit times, `err_pulse` is high for exactly one cycle if `err_mask` is 0. If `err_mask` is 1, it stays 0.
- R5: `brk_flag` stays 1 until `clr_brk` is 1. It drops in the cycle after that pulse. A `clr_brk` pulse while the flag is 0 has no effect.
- R6: `sync_win` rises on the first falling edge after the break flag has been cleared. Falling edges with no break, or while the flag is still set, leave `sync_win` at 0 and produce no `reload_vld`.
- R7: `sync_win` falls on the fifth falling edge counted from the one that opened it.
- R8: On that fifth edge, `reload_vld` pulses for one cycle. `reload_out` takes the value ((t5 − t1) mod 2^16)/8 − 1 mod 2^16, where t1 and t5 are tick-timer values at the opening and closing edges. The timer counts `os_tick` pulses.
- R9: Break timing after an update uses the new divisor. A low of 11.5 new bit times does not flag a break. A low of 12 new bit times plus margin does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_in | input | 1 | Raw serial line, 1 = recessive |
| os_tick | input | 1 | Oversampling tick enable |
| err_mask | input | 1 | 1 suppresses the nine-bit error pulse |
| clr_brk | input | 1 | Write-one-to-clear for the break flag |
| brk_flag | output | 1 | Sticky break flag and interrupt level |
| err_pulse | output | 1 | One-cycle receive-error pulse |
| sync_win | output | 1 | Sync capture window |
| reload_out | output | 16 | Current baud divisor (reload value) |
| reload_vld | output | 1 | One-cycle strobe on a new divisor |

## Verification
The input change reaches the synchronized line two clock edges after `rx_in` is driven. The falling-edge result (the opening of `sync_win`, or the close together with `reload_vld`) is registered on the third edge. The bench therefore samples `sync_win` at least one full bit time after each drive, with bit times of five or more cycles. The break flag comes one edge after the twelfth bit tick. The error pulse comes one edge after the ninth bit tick. Break lows are therefore held four cycles past the threshold, and short lows stop half a bit time before it. Strobes are counted at falling clock edges, and their totals are compared after each sequence has settled.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HELD  = 2'd1,
        ST_ARMED = 2'd2,
        ST_SYNC  = 2'd3
    } lbs_state_t;
endpackage

// File: rtl/lbs_rx_front.sv
module lbs_rx_front (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic rx_s,
    output logic fall
);
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            last_q <= 1'b1;
        end else begin
            meta_q <= rx_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign rx_s = sync_q;
    assign fall = last_q & ~sync_q;
endmodule

// File: rtl/lbs_bit_timer.sv
module lbs_bit_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         restart,
    input  logic [W-1:0] reload,
    output logic         bit_tick
);
    logic [W-1:0] cnt_q;

    assign bit_tick = tick & ~restart & (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= reload;
        else if (tick)
            cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
    end
endmodule

// File: rtl/lbs_span_meter.sv
module lbs_span_meter #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          mark,
    output logic [TW-1:0] divisor_m1
);
    logic [TW-1:0] timer_q, start_q, span;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q <= '0;
            start_q <= '0;
        end else begin
            if (tick) timer_q <= timer_q + 1'b1;
            if (mark) start_q <= timer_q;
        end
    end

    assign span       = timer_q - start_q;
    assign divisor_m1 = (span >> 3) - 1'b1;
endmodule

// File: rtl/lin_brk_sync.sv
module lin_brk_sync #(
    parameter int TW         = 16,
    parameter int BRK_BITS   = 11,
    parameter int ERR_BITS   = 9,
    parameter int SYNC_FALLS = 5,
    parameter int DEF_RELOAD = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_in,
    input  logic          os_tick,
    input  logic          err_mask,
    input  logic          clr_brk,
    output logic          brk_flag,
    output logic          err_pulse,
    output logic          sync_win,
    output logic [TW-1:0] reload_out,
    output logic          reload_vld
);
    import lbs_pkg::*;

    localparam int LOW_W = $clog2(BRK_BITS + 2);
    localparam int FC_W  = $clog2(SYNC_FALLS + 1);
    localparam logic [LOW_W-1:0] LOW_BRK = LOW_W'(BRK_BITS);
    localparam logic [LOW_W-1:0] LOW_ERR = LOW_W'(ERR_BITS - 1);
    localparam logic [FC_W-1:0]  FC_LAST = FC_W'(SYNC_FALLS - 1);

    lbs_state_t    state_q, state_d;
    logic          rx_s, fall, bit_tick;
    logic [LOW_W-1:0] low_q;
    logic [FC_W-1:0]  fc_q;
    logic [TW-1:0] reload_q, calc;
    logic          brk_hit, err_hit, open_ev, close_ev;

    lbs_rx_front u_front (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rx_s(rx_s), .fall(fall)
    );

    lbs_bit_timer #(.W(TW)) u_bit (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .restart(fall),
        .reload(reload_q), .bit_tick(bit_tick)
    );

    assign open_ev = (state_q == ST_ARMED) & fall;

    lbs_span_meter #(.TW(TW)) u_span (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .mark(open_ev),
        .divisor_m1(calc)
    );

    assign brk_hit  = (state_q == ST_IDLE) & bit_tick & ~rx_s & (low_q == LOW_BRK);
    assign err_hit  = (state_q == ST_IDLE) & bit_tick & ~rx_s & (low_q == LOW_ERR);
    assign close_ev = (state_q == ST_SYNC) & fall & (fc_q == FC_LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (brk_hit)  state_d = ST_HELD;
            ST_HELD:  if (clr_brk)  state_d = ST_ARMED;
            ST_ARMED: if (fall)     state_d = ST_SYNC;
            ST_SYNC:  if (close_ev) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_flag   <= 1'b0;
            err_pulse  <= 1'b0;
            sync_win   <= 1'b0;
            reload_q   <= TW'(DEF_RELOAD);
            reload_vld <= 1'b0;
            low_q      <= '0;
            fc_q       <= '0;
        end else begin
            err_pulse  <= err_hit & ~err_mask;
            reload_vld <= close_ev;

            if (rx_s || state_q != ST_IDLE)
                low_q <= '0;
            else if (bit_tick && low_q != LOW_BRK)
                low_q <= low_q + 1'b1;

            if (brk_hit)
                brk_flag <= 1'b1;
            else if (state_q == ST_HELD && clr_brk)
                brk_flag <= 1'b0;

            if (open_ev) begin
                sync_win <= 1'b1;
                fc_q     <= FC_W'(1);
            end else if (close_ev) begin
                sync_win <= 1'b0;
                reload_q <= calc;
            end else if (state_q == ST_SYNC && fall) begin
                fc_q <= fc_q + 1'b1;
            end
        end
    end

    assign reload_out = reload_q;

    // R5: flag holds until a clear write
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        brk_flag && !clr_brk |=> brk_flag);

    // R2: flag rises only out of IDLE with the line low
    a_r2_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> $past(state_q == ST_IDLE && !rx_s));

    // R4: no error pulse while masked
    a_r4_mask_honoured: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(!err_mask));

    // R6: window opens only from the armed state
    a_r6_open_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_win) |-> $past(state_q == ST_ARMED));

    // R7: window closes together with the new divisor
    a_r7_close_loads: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_win) |-> reload_vld);

    // R8: strobe lasts one cycle
    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        reload_vld |=> !reload_vld);
endmodule

// File: tb/sim_lin_brk_sync.sv
module sim_lin_brk_sync;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, rx_in, os_tick, err_mask, clr_brk;
    logic        brk_flag, err_pulse, sync_win, reload_vld;
    logic [15:0] reload_out;

    lin_brk_sync u0 (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_tick(os_tick),
        .err_mask(err_mask), .clr_brk(clr_brk), .brk_flag(brk_flag),
        .err_pulse(err_pulse), .sync_win(sync_win),
        .reload_out(reload_out), .reload_vld(reload_vld)
    );

    int checks = 0, errors = 0;
    int err_seen = 0, vld_seen = 0, exp_err = 0, exp_vld = 0;
    int exp_rel = 15;
    logic [15:0] last_rel = '0;
    bit tick_half = 0;
    bit done = 0;

    always @(negedge clk) begin
        os_tick <= tick_half ? ~os_tick : 1'b1;
        if (rst_n) begin
            if (err_pulse) err_seen++;
            if (reload_vld) begin vld_seen++; last_rel = reload_out; end
        end
    end

    function automatic logic [15:0] exp_reload(int span_ticks);
        logic [15:0] s;
        s = 16'(span_ticks);
        return (s >> 3) - 16'd1;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic low_for(int n);
        rx_in = 1'b0;
        wait_n(n);
        rx_in = 1'b1;
        wait_n(6);
    endtask

    task automatic clear_pulse();
        clr_brk = 1'b1;
        wait_n(1);
        clr_brk = 1'b0;
        wait_n(1);
    endtask

    // sync byte: start 0, data 1010_1010 pattern on the line, stop 1
    task automatic send_sync(int p, int span_ticks);
        bit lv [10] = '{0,1,0,1,0,1,0,1,0,1};
        for (int i = 0; i < 10; i++) begin
            rx_in = lv[i];
            wait_n(p);
            if (i == 1) chk(sync_win == 1'b1, "R6 window open", sync_win, 1);
        end
        exp_vld++;
        chk(sync_win == 1'b0, "R7 window closed", sync_win, 0);
        chk(vld_seen == exp_vld, "R8 strobe count", vld_seen, exp_vld);
        chk(last_rel == exp_reload(span_ticks), "R8 reload value", last_rel, exp_reload(span_ticks));
        chk(reload_out == exp_reload(span_ticks), "R8 reload held", reload_out, exp_reload(span_ticks));
        exp_rel = exp_reload(span_ticks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_v;
        int p, bt;
        seed_v = $urandom(1234);
        rst_n = 1'b0; rx_in = 1'b1; err_mask = 1'b0; clr_brk = 1'b0; os_tick = 1'b1;
        wait_n(4);
        chk(brk_flag == 0 && err_pulse == 0, "R1 flags reset", brk_flag, 0);
        chk(sync_win == 0 && reload_vld == 0, "R1 window reset", sync_win, 0);
        chk(reload_out == 16'd15, "R1 reload reset", reload_out, 15);
        rst_n = 1'b1;
        wait_n(4);

        // R6: edges with no break are ignored
        for (int i = 0; i < 6; i++) low_for(3);
        chk(sync_win == 0, "R6 no break edges", sync_win, 0);
        chk(vld_seen == 0, "R6 no strobe", vld_seen, 0);

        // R2/R4: 11.5 bit times low, unmasked
        bt = exp_rel + 1;
        low_for(11 * bt + bt / 2);
        exp_err++;
        chk(brk_flag == 0, "R2 short low", brk_flag, 0);
        chk(err_seen == exp_err, "R4 error pulse", err_seen, exp_err);

        // R3: two 8-bit lows split by a high
        rx_in = 1'b0; wait_n(8 * bt); rx_in = 1'b1; wait_n(bt);
        low_for(8 * bt);
        chk(brk_flag == 0, "R3 split low flag", brk_flag, 0);
        chk(err_seen == exp_err, "R3 split low error", err_seen, exp_err);

        // R4: masked error
        err_mask = 1'b1;
        low_for(10 * bt);
        chk(err_seen == exp_err, "R4 masked", err_seen, exp_err);

        // R5: clear with flag low has no effect
        clear_pulse();
        chk(brk_flag == 0, "R5 idle clear", brk_flag, 0);

        // R2: break
        low_for(12 * bt + 4);
        chk(brk_flag == 1, "R2 break set", brk_flag, 1);

        // R6/R5: edges while flag is set are ignored
        for (int i = 0; i < 5; i++) low_for(3);
        chk(sync_win == 0, "R6 held edges", sync_win, 0);
        chk(brk_flag == 1, "R5 flag sticky", brk_flag, 1);
        chk(vld_seen == 0, "R6 held no strobe", vld_seen, 0);
        clear_pulse();
        chk(brk_flag == 0, "R5 cleared", brk_flag, 0);
        send_sync(20, 160);

        // random rounds
        for (int r = 0; r < 6; r++) begin
            p = $urandom_range(5, 60);
            err_mask = 1'($urandom_range(0, 1));
            bt = exp_rel + 1;
            low_for(11 * bt + bt / 2);
            if (!err_mask) exp_err++;
            chk(brk_flag == 0, "R9 short low new divisor", brk_flag, 0);
            low_for(12 * bt + 4);
            if (!err_mask) exp_err++;
            chk(brk_flag == 1, "R9 break new divisor", brk_flag, 1);
            chk(err_seen == exp_err, "R4 error count", err_seen, exp_err);
            clear_pulse();
            chk(brk_flag == 0, "R5 cleared", brk_flag, 0);
            send_sync(p, 8 * p);
        end

        // R8: tick every other cycle
        bt = exp_rel + 1;
        low_for(12 * bt + 4);
        chk(brk_flag == 1, "R2 break before half tick", brk_flag, 1);
        clear_pulse();
        tick_half = 1;
        wait_n(3);
        send_sync(40, 160);
        tick_half = 0;
        wait_n(3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule